// File: doc/BRIEF.md
# Stateless NAT64 Address Translator

This block rewrites the source and destination addresses of an already parsed packet header when the packet crosses between the IPv6 and IPv4 worlds. Each lookup carries both address pairs and a family bit. An IPv6 packet leaves with IPv4 addresses. An IPv4 packet leaves with IPv6 addresses. The result appears a fixed two cycles after the valid strobe, and nothing can stall it.

Each address has a role. The remote address is the one on the IPv4-only side: the destination of an IPv6 packet, or the source of an IPv4 packet. A remote address may be resolved by a configured /96 prefix, which stands for the whole IPv4 space, with the IPv4 address in the low 32 bits. The local address is the one on the IPv6 side. It must be found in a small table. That table holds single-host mappings and subnet mappings, and the subnet mappings are chosen by longest prefix match.

A packet is translated only when both of its addresses resolve. Otherwise it is flagged for the controller. The controller installs entries through a write port and reinjects the packet, which then translates.

Top module: `nat64_xlate`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high. With it, `out_is_v6` equals the inverse of that lookup's `in_is_v6`.
- R2: Without a table match, a remote address is resolved from the /96 prefix `cfg_pfx96`. An IPv6 destination whose bits 127:32 equal `cfg_pfx96` becomes its bits 31:0. An IPv4 source always becomes `{cfg_pfx96, source}`.
- R3: An exact entry (`wr_to_pfx`=0) maps its IPv6 address one-to-one to its IPv4 address, in both directions and for either address role.
- R4: A prefix entry (`wr_to_pfx`=1) has length L. It matches an IPv4 address whose top L bits equal those of its IPv4 base. It matches an IPv6 address whose bits 127:32 equal its IPv6 base and whose next L bits agree with that base. The low 32-L host bits are carried over unchanged, and the top bits come from the other base.
- R5: An exact match takes precedence over a prefix match. A prefix match takes precedence over the /96 embedding.
- R6: Among matching prefix entries, the longest length wins. A tie goes to the lowest index. Among duplicate exact entries, the lowest index wins.
- R7: A lookup with an unresolved address gives `out_hit`=0 and `out_punt`=1, and all four output addresses are zero. When both addresses resolve, the block gives `out_hit`=1 and `out_punt`=0.
- R8: A write (`wr_en`, `wr_idx`, `wr_vld`) affects only lookups that start in later cycles. A lookup in the same cycle sees the old table. Writing `wr_vld`=0 removes the entry.
- R9: After reset every entry is empty and all outputs are zero.
- R10: When `out_valid` is low, all outputs are zero. While `out_valid` is high, the addresses of the family not produced are zero.
- R11: A prefix length above 32 is stored as 32. A length of 0 matches every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pfx96 | input | 96 | Upper 96 bits of the IPv4-embedding prefix |
| in_valid | input | 1 | Lookup strobe |
| in_is_v6 | input | 1 | 1: header is IPv6, 0: header is IPv4 |
| in_src6 | input | 128 | IPv6 source (used when `in_is_v6`=1) |
| in_dst6 | input | 128 | IPv6 destination (used when `in_is_v6`=1) |
| in_src4 | input | 32 | IPv4 source (used when `in_is_v6`=0) |
| in_dst4 | input | 32 | IPv4 destination (used when `in_is_v6`=0) |
| wr_en | input | 1 | Table write strobe |
| wr_to_pfx | input | 1 | 0: exact table, 1: prefix table |
| wr_idx | input | 3 | Entry index |
| wr_vld | input | 1 | Entry valid bit to store |
| wr_a6 | input | 128 | IPv6 address or base |
| wr_a4 | input | 32 | IPv4 address or base |
| wr_len | input | 6 | Prefix length, 0 to 32 |
| out_valid | output | 1 | Result strobe |
| out_is_v6 | output | 1 | 1: result addresses are IPv6 |
| out_src6 | output | 128 | Translated IPv6 source |
| out_dst6 | output | 128 | Translated IPv6 destination |
| out_src4 | output | 32 | Translated IPv4 source |
| out_dst4 | output | 32 | Translated IPv4 destination |
| out_hit | output | 1 | Both addresses translated |
| out_punt | output | 1 | Send to controller |

## Verification
Several behaviours are checked by the assertions on every cycle:
- the two-cycle latency and the family flip;
- the zeroing of outputs on a punt or when idle;
- the rule that an IPv4 source, or an IPv6 destination inside the /96 prefix, always resolves;
- the clamping of prefix lengths.

Other behaviours only the bench scenarios can show. These are the actual translated values, the precedence between exact, prefix and /96 matches, longest-prefix and tie ordering, and the rule that a write in the same cycle as a lookup is not seen by that lookup. The bench sweeps every prefix length on both sides of the prefix boundary and every exact slot in both directions.

// File: rtl/nat64_pkg.sv
package nat64_pkg;

    localparam int unsigned A6W  = 128;
    localparam int unsigned A4W  = 32;
    localparam int unsigned HIW  = A6W - A4W;
    localparam int unsigned LENW = $clog2(A4W + 1);

    typedef logic [A6W-1:0]  addr6_t;
    typedef logic [A4W-1:0]  addr4_t;
    typedef logic [LENW-1:0] plen_t;

    typedef struct packed {
        logic   vld;
        addr6_t a6;
        addr4_t a4;
    } exact_ent_t;

    typedef struct packed {
        logic   vld;
        addr6_t a6;
        addr4_t a4;
        plen_t  len;
    } pfx_ent_t;

    typedef struct packed {
        logic   from_v6;
        addr6_t a6;
        addr4_t a4;
    } query_t;

    typedef struct packed {
        logic   hit;
        addr6_t r6;
        addr4_t r4;
    } answer_t;

    typedef struct packed {
        logic    vld;
        logic    to_v6;
        answer_t src;
        answer_t dst;
    } stage1_t;

    typedef struct packed {
        logic   vld;
        logic   to_v6;
        logic   hit;
        logic   punt;
        addr6_t src6;
        addr6_t dst6;
        addr4_t src4;
        addr4_t dst4;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    // ones in the top len bits of an IPv4-sized word
    function automatic addr4_t pfx_mask(plen_t len);
        if (len == '0)
            return '0;
        else if (len >= plen_t'(A4W))
            return '1;
        else
            return ~({A4W{1'b1}} >> len);
    endfunction

endpackage

// File: rtl/nat64_exact_tbl.sv
module nat64_exact_tbl
    import nat64_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3,
    parameter int unsigned NQ = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic                wr_vld,
    input  addr6_t              wr_a6,
    input  addr4_t              wr_a4,
    input  query_t  [NQ-1:0]    q,
    output answer_t [NQ-1:0]    ans
);

    exact_ent_t [N-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < int'(N); i++) begin
            if (wr_en && wr_idx == IW'(i)) begin
                ent_d[i].vld = wr_vld;
                ent_d[i].a6  = wr_a6;
                ent_d[i].a4  = wr_a4;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    for (genvar g = 0; g < int'(NQ); g++) begin : g_port
        answer_t ans_g;
        // scan downward so the lowest matching index is kept
        always_comb begin
            logic m;
            ans_g = '0;
            m     = 1'b0;
            for (int i = int'(N) - 1; i >= 0; i--) begin
                m = ent_q[i].vld &&
                    (q[g].from_v6 ? (ent_q[i].a6 == q[g].a6)
                                  : (ent_q[i].a4 == q[g].a4));
                if (m) begin
                    ans_g.hit = 1'b1;
                    ans_g.r6  = ent_q[i].a6;
                    ans_g.r4  = ent_q[i].a4;
                end
            end
        end
        assign ans[g] = ans_g;
    end

    for (genvar i = 0; i < int'(N); i++) begin : g_chk
        // R8
        exact_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IW'(i) && !wr_vld) |=> !ent_q[i].vld);
    end

endmodule

// File: rtl/nat64_pfx_tbl.sv
module nat64_pfx_tbl
    import nat64_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3,
    parameter int unsigned NQ = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic                wr_vld,
    input  addr6_t              wr_a6,
    input  addr4_t              wr_a4,
    input  plen_t               wr_len,
    input  query_t  [NQ-1:0]    q,
    output answer_t [NQ-1:0]    ans
);

    pfx_ent_t [N-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < int'(N); i++) begin
            if (wr_en && wr_idx == IW'(i)) begin
                ent_d[i].vld = wr_vld;
                ent_d[i].a6  = wr_a6;
                ent_d[i].a4  = wr_a4;
                ent_d[i].len = (wr_len > plen_t'(A4W)) ? plen_t'(A4W) : wr_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    for (genvar g = 0; g < int'(NQ); g++) begin : g_port
        answer_t ans_g;
        always_comb begin
            plen_t  best;
            addr4_t mk;
            logic   m;
            ans_g = '0;
            best  = '0;
            mk    = '0;
            m     = 1'b0;
            for (int i = 0; i < int'(N); i++) begin
                mk = pfx_mask(ent_q[i].len);
                if (q[g].from_v6)
                    m = ent_q[i].vld &&
                        (q[g].a6[A6W-1:A4W] == ent_q[i].a6[A6W-1:A4W]) &&
                        (((q[g].a6[A4W-1:0] ^ ent_q[i].a6[A4W-1:0]) & mk) == '0);
                else
                    m = ent_q[i].vld && (((q[g].a4 ^ ent_q[i].a4) & mk) == '0);
                // strict compare keeps the lower index on equal length
                if (m && (!ans_g.hit || ent_q[i].len > best)) begin
                    ans_g.hit = 1'b1;
                    best      = ent_q[i].len;
                    ans_g.r4  = (ent_q[i].a4 & mk) | (q[g].a6[A4W-1:0] & ~mk);
                    ans_g.r6  = {ent_q[i].a6[A6W-1:A4W],
                                 (ent_q[i].a6[A4W-1:0] & mk) | (q[g].a4 & ~mk)};
                end
            end
        end
        assign ans[g] = ans_g;
    end

    for (genvar i = 0; i < int'(N); i++) begin : g_chk
        // R11
        len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IW'(i) && wr_len > plen_t'(A4W))
            |=> ent_q[i].len == plen_t'(A4W));
    end

endmodule

// File: rtl/nat64_xlate.sv
module nat64_xlate
    import nat64_pkg::*;
#(
    parameter int unsigned N_SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [95:0]                  cfg_pfx96,
    input  logic                         in_valid,
    input  logic                         in_is_v6,
    input  logic [127:0]                 in_src6,
    input  logic [127:0]                 in_dst6,
    input  logic [31:0]                  in_src4,
    input  logic [31:0]                  in_dst4,
    input  logic                         wr_en,
    input  logic                         wr_to_pfx,
    input  logic [$clog2(N_SLOTS)-1:0]   wr_idx,
    input  logic                         wr_vld,
    input  logic [127:0]                 wr_a6,
    input  logic [31:0]                  wr_a4,
    input  logic [5:0]                   wr_len,
    output logic                         out_valid,
    output logic                         out_is_v6,
    output logic [127:0]                 out_src6,
    output logic [127:0]                 out_dst6,
    output logic [31:0]                  out_src4,
    output logic [31:0]                  out_dst4,
    output logic                         out_hit,
    output logic                         out_punt
);

    localparam int unsigned IW = $clog2(N_SLOTS);
    localparam int unsigned NQ = 2;   // source and destination

    query_t  [NQ-1:0] q;
    answer_t [NQ-1:0] ex_ans, px_ans;
    pipe_t            st_d, st_q;

    always_comb begin
        q[0].from_v6 = in_is_v6;
        q[0].a6      = in_src6;
        q[0].a4      = in_src4;
        q[1].from_v6 = in_is_v6;
        q[1].a6      = in_dst6;
        q[1].a4      = in_dst4;
    end

    nat64_exact_tbl #(.N(N_SLOTS), .IW(IW), .NQ(NQ)) u_exact (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && !wr_to_pfx),
        .wr_idx (wr_idx),
        .wr_vld (wr_vld),
        .wr_a6  (wr_a6),
        .wr_a4  (wr_a4),
        .q      (q),
        .ans    (ex_ans)
    );

    nat64_pfx_tbl #(.N(N_SLOTS), .IW(IW), .NQ(NQ)) u_pfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && wr_to_pfx),
        .wr_idx (wr_idx),
        .wr_vld (wr_vld),
        .wr_a6  (wr_a6),
        .wr_a4  (wr_a4),
        .wr_len (wr_len),
        .q      (q),
        .ans    (px_ans)
    );

    // exact first, then prefix, then /96 embedding for the remote role
    function automatic answer_t resolve(answer_t ex, answer_t px, logic remote,
                                        query_t qq, logic [HIW-1:0] pfx);
        answer_t r;
        r = '0;
        if (ex.hit)
            r = ex;
        else if (px.hit)
            r = px;
        else if (remote) begin
            if (qq.from_v6) begin
                if (qq.a6[A6W-1:A4W] == pfx) begin
                    r.hit = 1'b1;
                    r.r4  = qq.a6[A4W-1:0];
                end
            end else begin
                r.hit = 1'b1;
                r.r6  = {pfx, qq.a4};
            end
        end
        return r;
    endfunction

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.s1.vld   = 1'b1;
            st_d.s1.to_v6 = !in_is_v6;
            st_d.s1.src   = resolve(ex_ans[0], px_ans[0], !in_is_v6, q[0], cfg_pfx96);
            st_d.s1.dst   = resolve(ex_ans[1], px_ans[1],  in_is_v6, q[1], cfg_pfx96);
        end
        if (st_q.s1.vld) begin
            st_d.s2.vld   = 1'b1;
            st_d.s2.to_v6 = st_q.s1.to_v6;
            st_d.s2.hit   = st_q.s1.src.hit && st_q.s1.dst.hit;
            st_d.s2.punt  = !(st_q.s1.src.hit && st_q.s1.dst.hit);
            if (st_q.s1.src.hit && st_q.s1.dst.hit) begin
                if (st_q.s1.to_v6) begin
                    st_d.s2.src6 = st_q.s1.src.r6;
                    st_d.s2.dst6 = st_q.s1.dst.r6;
                end else begin
                    st_d.s2.src4 = st_q.s1.src.r4;
                    st_d.s2.dst4 = st_q.s1.dst.r4;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.s2.vld;
    assign out_is_v6 = st_q.s2.to_v6;
    assign out_src6  = st_q.s2.src6;
    assign out_dst6  = st_q.s2.dst6;
    assign out_src4  = st_q.s2.src4;
    assign out_dst4  = st_q.s2.dst4;
    assign out_hit   = st_q.s2.hit;
    assign out_punt  = st_q.s2.punt;

    // cycles since reset, saturating, so $past never reaches into reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R1
    lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n || age_q != 2'd2)
        out_valid == $past(in_valid, 2));

    // R1
    dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n || age_q != 2'd2)
        out_valid |-> (out_is_v6 == !$past(in_is_v6, 2)));

    // R7
    punt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_punt |-> (!out_hit && out_src6 == '0 && out_dst6 == '0 &&
                      out_src4 == '0 && out_dst4 == '0));

    // R2
    v4_embed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_v6) |=> st_q.s1.src.hit);

    // R2
    pfx96_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_v6 && in_dst6[127:32] == cfg_pfx96) |=> st_q.s1.dst.hit);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_punt && !out_is_v6 && out_src6 == '0 &&
                        out_dst6 == '0 && out_src4 == '0 && out_dst4 == '0));

    // R10
    family_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_is_v6 ? (out_src4 == '0 && out_dst4 == '0)
                                 : (out_src6 == '0 && out_dst6 == '0)));

endmodule

// File: tb/nat64_xlate_test.sv
module nat64_xlate_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [95:0] CFG = 96'h20010db8_00230000_00000000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [95:0]  cfg_pfx96;
    logic         in_valid, in_is_v6;
    logic [127:0] in_src6, in_dst6;
    logic [31:0]  in_src4, in_dst4;
    logic         wr_en, wr_to_pfx, wr_vld;
    logic [2:0]   wr_idx;
    logic [127:0] wr_a6;
    logic [31:0]  wr_a4;
    logic [5:0]   wr_len;
    logic         out_valid, out_is_v6, out_hit, out_punt;
    logic [127:0] out_src6, out_dst6;
    logic [31:0]  out_src4, out_dst4;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nat64_xlate #(.N_SLOTS(8)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_pfx96(cfg_pfx96),
        .in_valid(in_valid), .in_is_v6(in_is_v6),
        .in_src6(in_src6), .in_dst6(in_dst6), .in_src4(in_src4), .in_dst4(in_dst4),
        .wr_en(wr_en), .wr_to_pfx(wr_to_pfx), .wr_idx(wr_idx), .wr_vld(wr_vld),
        .wr_a6(wr_a6), .wr_a4(wr_a4), .wr_len(wr_len),
        .out_valid(out_valid), .out_is_v6(out_is_v6),
        .out_src6(out_src6), .out_dst6(out_dst6), .out_src4(out_src4), .out_dst4(out_dst4),
        .out_hit(out_hit), .out_punt(out_punt)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench-side table image
    bit           ev [8];
    logic [127:0] e6 [8];
    logic [31:0]  e4 [8];
    bit           pv [8];
    logic [127:0] p6 [8];
    logic [31:0]  p4 [8];
    int           pl [8];

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] top_bits(int l);
        logic [63:0] m;
        m = ((64'd1 << l) - 64'd1) << (32 - l);
        return m[31:0];
    endfunction

    function automatic void mdl_one(bit v6in, logic [127:0] a6, logic [31:0] a4, bit remote,
                                    output bit hit, output logic [127:0] r6, output logic [31:0] r4);
        int best;
        logic [31:0] m;
        bit mt;
        hit = 0; r6 = '0; r4 = '0; best = -1;
        for (int i = 0; i < 8; i++) begin
            if (!hit && ev[i] && (v6in ? (e6[i] == a6) : (e4[i] == a4))) begin
                hit = 1; r6 = e6[i]; r4 = e4[i];
            end
        end
        if (hit) return;
        for (int i = 0; i < 8; i++) begin
            m = top_bits(pl[i]);
            if (v6in) mt = pv[i] && a6[127:32] == p6[i][127:32] && (a6[31:0] & m) == (p6[i][31:0] & m);
            else      mt = pv[i] && (a4 & m) == (p4[i] & m);
            if (mt && pl[i] > best) begin
                best = pl[i];
                r4 = (p4[i] & m) | (a6[31:0] & ~m);
                r6 = {p6[i][127:32], (p6[i][31:0] & m) | (a4 & ~m)};
            end
        end
        if (best >= 0) begin hit = 1; return; end
        if (remote) begin
            if (v6in && a6[127:32] == CFG) begin hit = 1; r4 = a6[31:0]; end
            else if (!v6in) begin hit = 1; r6 = {CFG, a4}; end
        end
    endfunction

    function automatic void mdl_wr(bit pfx, int idx, bit v, logic [127:0] a6, logic [31:0] a4, int len);
        if (pfx) begin
            pv[idx] = v; p6[idx] = a6; p4[idx] = a4; pl[idx] = (len > 32) ? 32 : len;
        end else begin
            ev[idx] = v; e6[idx] = a6; e4[idx] = a4;
        end
    endfunction

    task automatic wr(bit pfx, int idx, bit v, logic [127:0] a6, logic [31:0] a4, int len);
        @(negedge clk);
        wr_en = 1; wr_to_pfx = pfx; wr_idx = idx[2:0]; wr_vld = v;
        wr_a6 = a6; wr_a4 = a4; wr_len = len[5:0];
        @(negedge clk);
        wr_en = 0;
        mdl_wr(pfx, idx, v, a6, a4, len);
    endtask

    // one lookup; optionally a table write in the same cycle
    task automatic lk(string req, bit v6, logic [127:0] s6, logic [127:0] d6,
                      logic [31:0] s4, logic [31:0] d4,
                      bit w = 0, bit wp = 0, int wi = 0, bit wv = 0,
                      logic [127:0] w6 = '0, logic [31:0] w4 = '0, int wl = 0);
        bit sh, dh, h;
        logic [127:0] sr6, dr6, x_s6, x_d6;
        logic [31:0]  sr4, dr4, x_s4, x_d4;
        mdl_one(v6, s6, s4, !v6, sh, sr6, sr4);
        mdl_one(v6, d6, d4,  v6, dh, dr6, dr4);
        h = sh && dh;
        x_s6 = (!v6 && h) ? sr6 : '0;
        x_d6 = (!v6 && h) ? dr6 : '0;
        x_s4 = ( v6 && h) ? sr4 : '0;
        x_d4 = ( v6 && h) ? dr4 : '0;
        @(negedge clk);
        in_valid = 1; in_is_v6 = v6; in_src6 = s6; in_dst6 = d6; in_src4 = s4; in_dst4 = d4;
        if (w) begin
            wr_en = 1; wr_to_pfx = wp; wr_idx = wi[2:0]; wr_vld = wv;
            wr_a6 = w6; wr_a4 = w4; wr_len = wl[5:0];
        end
        @(negedge clk);
        in_valid = 0; wr_en = 0;
        if (w) mdl_wr(wp, wi, wv, w6, w4, wl);
        chk(!out_valid, "R1", "early out_valid", 128'(out_valid), 128'(0));
        @(negedge clk);
        chk(out_valid, "R1", "out_valid", 128'(out_valid), 128'(1));
        chk(out_is_v6 == !v6, "R1", "out_is_v6", 128'(out_is_v6), 128'(!v6));
        chk(out_hit == h && out_punt == !h, {req, "/R7"}, "hit,punt",
            128'({out_hit, out_punt}), 128'({h, !h}));
        chk(out_src6 == x_s6, req, "src6", out_src6, x_s6);
        chk(out_dst6 == x_d6, req, "dst6", out_dst6, x_d6);
        chk(out_src4 == x_s4, req, "src4", 128'(out_src4), 128'(x_s4));
        chk(out_dst4 == x_d4, req, "dst4", 128'(out_dst4), 128'(x_d4));
    endtask

    function automatic logic [127:0] host6(int i);
        return 128'h20010db8_00420000_00000000_00000040 + 128'(i);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [127:0] b6;
        logic [31:0]  b4, hst;
        for (int i = 0; i < 8; i++) begin
            ev[i] = 0; e6[i] = '0; e4[i] = '0; pv[i] = 0; p6[i] = '0; p4[i] = '0; pl[i] = 0;
        end
        rst_n = 0; cfg_pfx96 = CFG; in_valid = 0; in_is_v6 = 0;
        in_src6 = '0; in_dst6 = '0; in_src4 = '0; in_dst4 = '0;
        wr_en = 0; wr_to_pfx = 0; wr_idx = '0; wr_vld = 0; wr_a6 = '0; wr_a4 = '0; wr_len = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!out_valid && !out_hit && !out_punt && out_src6 == '0 && out_dst4 == '0,
            "R9", "reset outputs", 128'({out_valid, out_hit, out_punt}), 128'(0));
        rst_n = 1;
        @(negedge clk);
        chk(!out_valid && out_dst6 == '0 && out_src4 == '0, "R10", "idle outputs",
            128'(out_valid), 128'(0));

        // R7 empty table: local source misses
        lk("R7", 1, host6(0), {CFG, 32'h0a00002a}, '0, '0);
        // R2 destination outside /96 with no entry also misses
        lk("R2", 1, host6(0), 128'h20010db8_00990000_00000000_0a00002a, '0, '0);

        // R8 controller installs entry, reinjected packet hits
        wr(0, 0, 1, host6(0), 32'h0a000042, 0);
        lk("R8", 1, host6(0), {CFG, 32'h0a00002a}, '0, '0);
        // R8 write in the same cycle is not seen, next lookup is
        lk("R8", 1, host6(1), {CFG, 32'h0a00002b}, '0, '0, 1, 0, 1, 1, host6(1), 32'h0a000043, 0);
        lk("R8", 1, host6(1), {CFG, 32'h0a00002b}, '0, '0);

        // R3 sweep of all exact slots, both directions; R2 embedding on the remote side
        for (int i = 0; i < 8; i++) wr(0, i, 1, host6(i), 32'h0a000040 + i, 0);
        for (int i = 0; i < 8; i++) begin
            lk("R3", 1, host6(i), {CFG, 32'hc6336400 + i}, '0, '0);
            lk("R3", 0, '0, '0, 32'h08080800 + i, 32'h0a000040 + i);
        end

        // R4 / R11 prefix length sweep, inside and just outside the prefix
        b6 = 128'h20010db8_00550000_00000000_c0de0000;
        b4 = 32'h0a010000;
        for (int l = 0; l <= 33; l++) begin
            int len;
            len = (l == 33) ? 40 : l;   // R11 oversize length acts as 32
            wr(1, 0, 1, b6, b4, len);
            hst = 32'h00005a5a & ~top_bits(len > 32 ? 32 : len);
            lk("R4", 0, '0, '0, 32'hc6336401, b4 | hst);
            lk("R4", 1, {b6[127:32], b6[31:0] | hst}, {CFG, 32'h01020304}, '0, '0);
            if (len >= 1)
                lk("R11", 0, '0, '0, 32'hc6336401, b4 ^ (32'd1 << (32 - (len > 32 ? 32 : len))));
        end
        wr(1, 0, 0, '0, '0, 0);

        // R6 longest prefix, then tie to lowest index
        wr(1, 1, 1, 128'h20010db8_00610000_00000000_00000000, 32'h0a020000, 16);
        wr(1, 2, 1, 128'h20010db8_00620000_00000000_00000000, 32'h0a020300, 24);
        wr(1, 3, 1, 128'h20010db8_00630000_00000000_00000000, 32'h0a020300, 24);
        lk("R6", 0, '0, '0, 32'h01010101, 32'h0a020305);
        lk("R6", 0, '0, '0, 32'h01010101, 32'h0a020405);
        // R6 duplicate exact: lowest index kept
        wr(0, 6, 1, host6(3), 32'h0a0000ee, 0);
        lk("R6", 1, host6(3), {CFG, 32'h01010101}, '0, '0);
        // R5 exact over prefix
        wr(0, 7, 1, host6(77), 32'h0a020307, 0);
        lk("R5", 0, '0, '0, 32'h01010101, 32'h0a020307);
        // R5 prefix over /96 for a remote IPv6 destination
        wr(1, 4, 1, {CFG, 32'hc6330000}, 32'h0a050000, 16);
        lk("R5", 1, host6(2), {CFG, 32'hc6330011}, '0, '0);
        // R4 /96 prefix entry used in the IPv4 direction
        lk("R4", 0, '0, '0, 32'h0a050099, 32'h0a000045);

        // R8 removal
        wr(0, 0, 0, '0, '0, 0);
        lk("R8", 1, host6(0), {CFG, 32'h0a00002a}, '0, '0);

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule